// File: doc/BRIEF.md
# Floating-point status and control register

This block is the 32-bit control and status word that sits next to a floating-point arithmetic unit. Software writes it through a plain register port to choose the rounding direction, to choose whether subnormal operands are flushed to signed zero, and to decide which of the five IEEE exception classes raise a request toward the processor. The arithmetic unit reports each finished operation with a strobe and a five-bit event vector. The word turns those events into three things:
- a per-operation cause field, which shows what the latest operation raised;
- sticky accumulated flags, for exception classes that software has masked;
- a one-cycle exception request, for classes that software has enabled.

The accumulated flags can only be cleared by software. Writing 0 to a flag bit clears it and writing 1 leaves it as it is, so software can clear one flag without racing the hardware. A read-only summary bit reports whether any flag other than inexact is set. The reserved positions always read as zero.

Top module: `fpsc_top`

## Requirements
- R1: After a synchronous reset, `rd_data` is 0. So `round_mode` is 0 (nearest-even), `flush_denorm` is 0, all enables are 0 (masked), all flags and causes are 0, and `exc_req` is 0.
- R2: A write loads bits 1:0 into `round_mode` and bit 8 into `flush_denorm`. Both appear on the outputs and on `rd_data` one cycle later. The round-mode encoding is 0 nearest-even, 1 toward zero, 2 toward +inf and 3 toward -inf.
- R3: Bits 14:10 are the enables for invalid, overflow, divide-by-zero, underflow and inexact, in that order from bit 10 to bit 14. A write loads them and they read back unchanged.
- R4: When `op_done` is 1, each `op_exc[i]` sets flag bit 26+i only if enable bit 10+i is 0. The `op_exc` index order is 0 invalid, 1 overflow, 2 divide-by-zero, 3 underflow, 4 inexact. An enabled class, or any event while `op_done` is 0, leaves the flag unchanged.
- R5: A flag that is 1 stays 1. It is cleared only when a write has a 0 in that flag bit, and a 1 written there leaves the flag as it is.
- R6: If a write clears a flag in the same cycle that a masked event sets it, the flag ends up 1.
- R7: Bit 31 is read-only and equals the OR of flag bits 26 to 29. The inexact flag (bit 30) does not affect it.
- R8: Bits 7, 9 and 25:15 always read as 0, whatever is written to them.
- R9: Bits 6:2 hold the cause field, in the same class order as the enables. On every `op_done` they are loaded with `op_exc`, zeros included, and the load takes priority over a software write in the same cycle. At other times they hold their value or take the value written by software.
- R10: `exc_req` is 1 for exactly the cycle after an `op_done` in which some `op_exc[i]` has its enable at 1. In every other cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| op_done | input | 1 | Arithmetic operation complete strobe |
| op_exc | input | 5 | Event vector of the completing operation (0 invalid, 1 overflow, 2 div-by-zero, 3 underflow, 4 inexact) |
| rd_data | output | 32 | Current register value |
| round_mode | output | 2 | Rounding direction to the datapath |
| flush_denorm | output | 1 | Flush subnormals to signed zero |
| exc_req | output | 1 | Exception request pulse toward the processor |

## Verification
Every result is registered once. A write or an operation strobe applied before a rising edge shows up in `rd_data`, `round_mode`, `flush_denorm` and `exc_req` right after that edge. The bench drives its inputs on the falling edge and samples on the next falling edge, which is half a cycle after the result lands. It then checks a further cycle with `op_done` low, to confirm that `exc_req` has dropped back and that the flags have held. The exhaustive sweep covers all 32 enable patterns against all 32 event vectors, and the expected word is built arithmetically from R3, R4, R7 and R9.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
  localparam int REG_W     = 32;
  localparam int NEXC      = 5;
  localparam int RM_W      = 2;
  localparam int RM_LSB    = 0;
  localparam int CAUSE_LSB = 2;
  localparam int FLUSH_BIT = 8;
  localparam int EN_LSB    = 10;
  localparam int FLAG_LSB  = 26;
  localparam int SUM_BIT   = 31;
  localparam int SUM_W     = 4;   // flags folded into the summary bit

  typedef enum logic [RM_W-1:0] {
    RND_NEAREST = 2'd0,
    RND_ZERO    = 2'd1,
    RND_POS     = 2'd2,
    RND_NEG     = 2'd3
  } rnd_mode_e;
endpackage

// File: rtl/fpsc_ctrl_reg.sv
module fpsc_ctrl_reg
  import fpsc_pkg::*;
#(
  parameter int N_EXC = NEXC,
  parameter int RMW   = RM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [RMW-1:0]   wr_rm,
  input  logic             wr_flush,
  input  logic [N_EXC-1:0] wr_en_bits,
  output logic [RMW-1:0]   round_mode,
  output logic             flush_denorm,
  output logic [N_EXC-1:0] exc_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      round_mode   <= RMW'(RND_NEAREST);
      flush_denorm <= 1'b0;
      exc_en       <= '0;
    end else if (wr_en) begin
      round_mode   <= wr_rm;
      flush_denorm <= wr_flush;
      exc_en       <= wr_en_bits;
    end
  end

  // R2
  rm_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (round_mode == $past(wr_rm)) && (flush_denorm == $past(wr_flush)));

  // R3
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(exc_en));
endmodule

// File: rtl/fpsc_flag_cell.sv
module fpsc_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_keep,
  input  logic set_req,
  output logic flag_q
);
  logic sw_clr;
  assign sw_clr = wr_en & ~wr_keep;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= (flag_q & ~sw_clr) | set_req;
  end

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(wr_en && !wr_keep)) |=> flag_q);

  // R6
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_req |=> flag_q);

  // R5
  sw_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_keep && !set_req) |=> !flag_q);
endmodule

// File: rtl/fpsc_flag_bank.sv
module fpsc_flag_bank
  import fpsc_pkg::*;
#(
  parameter int N_EXC = NEXC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [N_EXC-1:0] wr_keep,
  input  logic             op_done,
  input  logic [N_EXC-1:0] op_exc,
  input  logic [N_EXC-1:0] exc_en,
  output logic [N_EXC-1:0] flags
);
  logic [N_EXC-1:0] set_req;
  assign set_req = {N_EXC{op_done}} & op_exc & ~exc_en;

  for (genvar i = 0; i < N_EXC; i++) begin : g_cell
    fpsc_flag_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_keep (wr_keep[i]),
      .set_req (set_req[i]),
      .flag_q  (flags[i])
    );

    // R4
    enabled_no_set_chk: assert property (@(posedge clk) disable iff (rst)
      (!flags[i] && !(op_done && op_exc[i] && !exc_en[i])) |=> !flags[i]);
  end
endmodule

// File: rtl/fpsc_cause_unit.sv
module fpsc_cause_unit
  import fpsc_pkg::*;
#(
  parameter int N_EXC = NEXC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [N_EXC-1:0] wr_cause,
  input  logic             op_done,
  input  logic [N_EXC-1:0] op_exc,
  input  logic [N_EXC-1:0] exc_en,
  output logic [N_EXC-1:0] cause,
  output logic             exc_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cause   <= '0;
      exc_req <= 1'b0;
    end else begin
      exc_req <= op_done & (|(op_exc & exc_en));
      if (op_done)    cause <= op_exc;
      else if (wr_en) cause <= wr_cause;
    end
  end

  // R9
  cause_load_chk: assert property (@(posedge clk) disable iff (rst)
    op_done |=> cause == $past(op_exc));

  // R10
  req_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (op_done && (|(op_exc & exc_en))) |=> exc_req);

  // R10
  req_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !op_done |=> !exc_req);
endmodule

// File: rtl/fpsc_top.sv
module fpsc_top
  import fpsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              op_done,
  input  logic [NEXC-1:0]   op_exc,
  output logic [REG_W-1:0]  rd_data,
  output logic [RM_W-1:0]   round_mode,
  output logic              flush_denorm,
  output logic              exc_req
);
  logic [NEXC-1:0] exc_en;
  logic [NEXC-1:0] flags;
  logic [NEXC-1:0] cause;

  fpsc_ctrl_reg #(.N_EXC(NEXC), .RMW(RM_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_rm        (wr_data[RM_LSB +: RM_W]),
    .wr_flush     (wr_data[FLUSH_BIT]),
    .wr_en_bits   (wr_data[EN_LSB +: NEXC]),
    .round_mode   (round_mode),
    .flush_denorm (flush_denorm),
    .exc_en       (exc_en)
  );

  fpsc_flag_bank #(.N_EXC(NEXC)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_keep (wr_data[FLAG_LSB +: NEXC]),
    .op_done (op_done),
    .op_exc  (op_exc),
    .exc_en  (exc_en),
    .flags   (flags)
  );

  fpsc_cause_unit #(.N_EXC(NEXC)) u_cause (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_cause (wr_data[CAUSE_LSB +: NEXC]),
    .op_done  (op_done),
    .op_exc   (op_exc),
    .exc_en   (exc_en),
    .cause    (cause),
    .exc_req  (exc_req)
  );

  // Reserved and read-only positions of the write value are dropped.
  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[SUM_BIT], wr_data[FLAG_LSB-1:EN_LSB+NEXC],
                            wr_data[FLUSH_BIT+1], wr_data[FLUSH_BIT-1]};

  always_comb begin
    rd_data = '0;
    rd_data[RM_LSB +: RM_W]    = round_mode;
    rd_data[CAUSE_LSB +: NEXC] = cause;
    rd_data[FLUSH_BIT]         = flush_denorm;
    rd_data[EN_LSB +: NEXC]    = exc_en;
    rd_data[FLAG_LSB +: NEXC]  = flags;
    rd_data[SUM_BIT]           = |flags[SUM_W-1:0];
  end

  // R7
  summary_track_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !op_done && !rd_data[SUM_BIT]) |=> !rd_data[SUM_BIT]);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (rd_data == '0) && !exc_req);
endmodule

// File: tb/test_fpsc_top.sv
module test_fpsc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        op_done = 1'b0;
  logic [4:0]  op_exc = '0;
  logic [31:0] rd_data;
  logic [1:0]  round_mode;
  logic        flush_denorm;
  logic        exc_req;

  int nchk = 0;
  int nerr = 0;

  fpsc_top i_fpsc_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .op_done(op_done), .op_exc(op_exc), .rd_data(rd_data),
    .round_mode(round_mode), .flush_denorm(flush_denorm), .exc_req(exc_req)
  );

  always #5 clk = ~clk;

  // Word layout per R2, R3, R4, R7, R9: rm 1:0, cause 6:2, flush 8,
  // enables 14:10, flags 30:26, summary 31.
  function automatic logic [31:0] mk(input logic [1:0] rm, input logic [4:0] cs,
                                     input logic fl, input logic [4:0] en,
                                     input logic [4:0] fg);
    logic [31:0] w;
    w = '0;
    w[1:0]   = rm;
    w[6:2]   = cs;
    w[8]     = fl;
    w[14:10] = en;
    w[30:26] = fg;
    w[31]    = |fg[3:0];
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply inputs at a falling edge; return at the next falling edge.
  task automatic cyc(input logic we, input logic [31:0] wd, input logic od, input logic [4:0] ev);
    wr_en = we; wr_data = wd; op_done = od; op_exc = ev;
    @(negedge clk);
    wr_en = 1'b0; op_done = 1'b0; op_exc = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 outputs", {29'b0, round_mode, flush_denorm}, 32'h0);
    check("R1 exc_req", {31'b0, exc_req}, 32'h0);

    // R2 round mode and flush control
    for (int rm = 0; rm < 4; rm++) begin
      for (int fl = 0; fl < 2; fl++) begin
        cyc(1'b1, mk(rm[1:0], 5'd0, fl[0], 5'd0, 5'd0) & 32'h7FFF_FFFF, 1'b0, 5'd0);
        check("R2 readback", rd_data, mk(rm[1:0], 5'd0, fl[0], 5'd0, 5'd0));
        check("R2 ports", {29'b0, round_mode, flush_denorm}, {29'b0, rm[1:0], fl[0]});
      end
    end

    // R8 reserved bits read zero; writing 1 to flags keeps them clear
    cyc(1'b1, 32'hFFFF_FFFF, 1'b0, 5'd0);
    check("R8 reserved", rd_data & 32'h03FF_8280, 32'h0);
    check("R8 word", rd_data, mk(2'd3, 5'h1F, 1'b1, 5'h1F, 5'h0));

    // R3 R4 R7 R9 R10 exhaustive enable x event sweep
    for (int en = 0; en < 32; en++) begin
      for (int ev = 0; ev < 32; ev++) begin
        logic [4:0] fg;
        fg = ev[4:0] & ~en[4:0];
        cyc(1'b1, mk(2'd0, 5'd0, 1'b0, en[4:0], 5'd0) & 32'h7FFF_FFFF, 1'b0, 5'd0);
        cyc(1'b0, 32'h0, 1'b1, ev[4:0]);
        check("R4 word after op", rd_data, mk(2'd0, ev[4:0], 1'b0, en[4:0], fg));
        check("R7 summary", {31'b0, rd_data[31]}, {31'b0, |fg[3:0]});
        check("R10 request", {31'b0, exc_req}, {31'b0, |(ev[4:0] & en[4:0])});
        cyc(1'b0, 32'h0, 1'b0, ev[4:0]);
        check("R9 hold without strobe", rd_data, mk(2'd0, ev[4:0], 1'b0, en[4:0], fg));
        check("R10 one-cycle pulse", {31'b0, exc_req}, 32'h0);
      end
    end

    // R5 sticky flags: write 1 keeps, write 0 clears that bit alone
    for (int i = 0; i < 5; i++) begin
      cyc(1'b1, 32'h0, 1'b0, 5'd0);
      cyc(1'b0, 32'h0, 1'b1, 5'h1F);
      cyc(1'b1, 32'h7C00_0000, 1'b0, 5'd0);
      check("R5 write ones keep", rd_data, mk(2'd0, 5'd0, 1'b0, 5'd0, 5'h1F));
      cyc(1'b1, {1'b0, ~(5'd1 << i), 26'd0}, 1'b0, 5'd0);
      check("R5 single clear", rd_data, mk(2'd0, 5'd0, 1'b0, 5'd0, 5'h1F & ~(5'd1 << i)));
    end

    // R6 hardware set beats software clear in the same cycle
    for (int i = 0; i < 5; i++) begin
      cyc(1'b0, 32'h0, 1'b1, 5'h1F);
      cyc(1'b1, 32'h0, 1'b1, 5'd1 << i);
      check("R6 set wins", rd_data, mk(2'd0, 5'd1 << i, 1'b0, 5'd0, 5'd1 << i));
    end

    // R9 software write of cause field when no strobe
    cyc(1'b1, 32'h0000_0054, 1'b0, 5'd0);
    check("R9 software cause", rd_data, mk(2'd0, 5'h15, 1'b0, 5'd0, 5'd0));

    // R1 reset again clears everything
    cyc(1'b1, 32'h7FFF_FFFF, 1'b0, 5'd0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 re-reset", rd_data, 32'h0);

    finish_run();
  end
endmodule